// File: doc/BRIEF.md
# Converter Serial Result Output Port

This block is the serial readout side of an 18-bit sampling converter. Each conversion delivers a ready-coded result word together with a one-cycle end-of-conversion strobe. The port shifts that word out, most significant bit first, on a single data line. In master mode the port generates the serial clock from the system clock through a fixed divider. It drives that clock out together with a frame sync of selectable polarity. In slave mode a host supplies the clock and qualifies it with an active-low chip select.

Static configuration inputs select the clock source, the serial clock polarity, the sync polarity and the master read mode. The read mode is either read-during-convert, which reads the previous result while the next conversion runs, or read-after-convert. In slave mode a serial input is shifted in behind the word, so several ports can share one data line in a chain. A read cut short by a new result raises a one-cycle error flag. All logic runs on the system clock. Slave-side inputs pass through a two-stage synchronizer, and the port acts on a host clock edge within three system clocks.

Top module: `adc_serial_port`

## Requirements
- R1: The result word is 18 bits and leaves on `sdout` most significant bit first. Each bit step presents the next lower bit.
- R2: Master mode (`cfg_slave`=0) runs the serial clock for exactly 18 periods of 2*DIV system clocks per read. Each period has its low half first (before inversion), and data changes at the end of each period. Outside a read the clock rests at its idle level.
- R3: In master mode `sync_out` is active from the cycle after a read starts until the 18th period ends. It is active high when `cfg_sync_inv`=0 and active low when `cfg_sync_inv`=1.
- R4: With `cfg_sclk_inv`=1 the master clock output is inverted. In slave mode the data-changing edge of `sclk_in` is the rising edge when `cfg_sclk_inv`=0 and the falling edge when it is 1. The other edge leaves `sdout` unchanged.
- R5: In master mode with `cfg_rd_during`=1, `conv_start` begins a read of the previously strobed result, and `eoc` alone starts nothing. With `cfg_rd_during`=0, `eoc` begins a read of the word present on `result_in` in that cycle. Strobes that arrive during a running read do not disturb it.
- R6: In slave mode every data-changing edge shifts the level on `sdin` into the low end of the word. That level reaches `sdout` after 18 edges, so two chained ports deliver 36 bits, the near port's word first.
- R7: In slave mode, `eoc` can arrive while `cs_n` is low after 1 to 17 data-changing edges. In that case `rd_err` is high for exactly one cycle, the new result replaces the unread one, the bit count restarts, and `sdout` shows the new word's MSB.
- R8: `sdout` is low when no master read is running, or in slave mode while `cs_n` is high. In slave mode `sync_out` stays inactive and `sclk_out` stays at its idle level. After reset all outputs are at these idle values and `rd_err` is low.
- R9: Raising `cs_n` aborts a slave read and clears its bit count. An `eoc` after `cs_n` falls again, with no clock edge in between, raises no error.
- R10: In slave mode, an `eoc` with `cs_n` high, or after all 18 bits have been clocked, loads the new word without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_slave | input | 1 | Clock source: 0 internal (master), 1 external (slave) |
| cfg_sclk_inv | input | 1 | Serial clock inversion |
| cfg_sync_inv | input | 1 | Frame sync polarity: 0 active high, 1 active low |
| cfg_rd_during | input | 1 | Master read mode: 1 previous result during conversion, 0 after conversion |
| conv_start | input | 1 | One-cycle strobe at the start of a conversion |
| eoc | input | 1 | One-cycle strobe when a result is ready on `result_in` |
| result_in | input | 18 | Coded conversion result |
| cs_n | input | 1 | Slave chip select, active low |
| sclk_in | input | 1 | External serial clock in slave mode |
| sdin | input | 1 | Chain input shifted in behind the word |
| sclk_out | output | 1 | Generated serial clock in master mode |
| sync_out | output | 1 | Frame sync in master mode |
| sdout | output | 1 | Serial data output |
| rd_err | output | 1 | One-cycle incomplete-read flag |

## Verification
The bench builds the port with its defaults: an 18-bit word, DIV=2 and two synchronizer stages. One master bit then lasts four system clocks and a whole frame lasts 72, short enough to sweep every combination of clock inversion, sync polarity and read mode bit by bit. A second instance feeds the first through `sdin`, which covers the 36-bit chained read. Sampling between the two host clock edges exposes the launch edge chosen by the inversion setting. Short reads cut off by a new result or by chip select cover the error flag and the abort path.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_WORD_W      = 18;
  localparam int unsigned SP_SYNC_STAGES = 2;

  // Resynchronized slave-side events seen by the shift core.
  typedef struct packed {
    logic launch;   // data-changing edge of the host clock
    logic cs_act;   // chip select asserted
    logic sd;       // chain input level
  } sp_slv_t;
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int unsigned    N       = 1,
  parameter int unsigned    STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] pipe_q, pipe_n;

  always_comb begin
    pipe_n = {pipe_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
    else        pipe_q <= pipe_n;
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/sp_slave_front.sv
module sp_slave_front import sp_pkg::*; #(
  parameter int unsigned STAGES = SP_SYNC_STAGES
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sclk_inv,
  input  logic    sclk_in,
  input  logic    cs_n,
  input  logic    sdin,
  output sp_slv_t slv
);
  logic [2:0] raw, syn;
  logic       sclk_d_q, sclk_d_n;
  logic       rise, fall;

  assign raw = {sclk_in, cs_n, sdin};

  sp_sync #(.N(3), .STAGES(STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_comb sclk_d_n = syn[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d_q <= 1'b0;
    else        sclk_d_q <= sclk_d_n;
  end

  assign rise       = syn[2] & ~sclk_d_q;
  assign fall       = ~syn[2] & sclk_d_q;
  assign slv.launch = sclk_inv ? fall : rise;
  assign slv.cs_act = ~syn[1];
  assign slv.sd     = syn[0];

  // R4
  launch_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slv.launch |=> !slv.launch);
endmodule

// File: rtl/sp_master_clkgen.sv
module sp_master_clkgen #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned DIV    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sclk_int,
  output logic shift
);
  localparam int unsigned    DW       = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int unsigned    BW       = $clog2(WORD_W);
  localparam logic [DW-1:0]  DIV_LAST = DW'(DIV - 1);
  localparam logic [BW-1:0]  BIT_LAST = BW'(WORD_W - 1);

  logic          busy_q, busy_n;
  logic          ph_q, ph_n;
  logic [DW-1:0] div_q, div_n;
  logic [BW-1:0] bit_q, bit_n;
  logic          div_wrap;

  assign div_wrap = busy_q && (div_q == DIV_LAST);

  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    div_n  = div_q;
    bit_n  = bit_q;
    if (start) begin
      busy_n = 1'b1;
      ph_n   = 1'b0;
      div_n  = '0;
      bit_n  = '0;
    end else if (busy_q) begin
      if (div_wrap) begin
        div_n = '0;
        ph_n  = ~ph_q;
        if (ph_q) begin
          if (bit_q == BIT_LAST) busy_n = 1'b0;
          else                   bit_n  = bit_q + 1'b1;
        end
      end else begin
        div_n = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      div_q  <= div_n;
      bit_q  <= bit_n;
    end
  end

  assign busy     = busy_q;
  assign sclk_int = ph_q;
  assign shift    = div_wrap && ph_q;

  // R2
  bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bit_q <= BIT_LAST));
  // R2
  end_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(shift));
  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !ph_q);
endmodule

// File: rtl/sp_shift_core.sv
module sp_shift_core import sp_pkg::*; #(
  parameter int unsigned WORD_W = SP_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slave,
  input  logic              rd_during,
  input  logic              eoc,
  input  logic [WORD_W-1:0] result_in,
  input  logic              m_start,
  input  logic              m_shift,
  input  logic              m_busy,
  input  sp_slv_t           slv,
  output logic              sdout,
  output logic              rd_err
);
  localparam int unsigned   CW       = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);

  logic [WORD_W-1:0] sh_q, sh_n, hold_q, hold_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              err_q, err_n;
  logic              s_started;

  assign s_started = slv.cs_act && (cnt_q != '0) && (cnt_q != CNT_FULL);

  always_comb begin
    sh_n   = sh_q;
    hold_n = eoc ? result_in : hold_q;
    cnt_n  = cnt_q;
    err_n  = 1'b0;
    if (!slave) begin
      cnt_n = '0;
      if (m_start)      sh_n = rd_during ? hold_q : result_in;
      else if (m_shift) sh_n = {sh_q[WORD_W-2:0], 1'b0};
    end else begin
      if (eoc) begin
        sh_n  = result_in;
        cnt_n = '0;
        err_n = s_started;
      end else if (!slv.cs_act) begin
        cnt_n = '0;
      end else if (slv.launch) begin
        sh_n = {sh_q[WORD_W-2:0], slv.sd};
        if (cnt_q != CNT_FULL) cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      hold_q <= hold_n;
      cnt_q  <= cnt_n;
      err_q  <= err_n;
    end
  end

  assign sdout  = (slave ? slv.cs_act : m_busy) & sh_q[WORD_W-1];
  assign rd_err = err_q;

  // R7
  rd_err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |=> !rd_err);
  // R7
  rd_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> ($past(eoc) && $past(slave)));
  // R6
  slv_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);
  // R9
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slv.cs_act |=> (cnt_q == '0));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port import sp_pkg::*; #(
  parameter int unsigned WORD_W      = SP_WORD_W,
  parameter int unsigned DIV         = 2,
  parameter int unsigned SYNC_STAGES = SP_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_slave,
  input  logic              cfg_sclk_inv,
  input  logic              cfg_sync_inv,
  input  logic              cfg_rd_during,
  input  logic              conv_start,
  input  logic              eoc,
  input  logic [WORD_W-1:0] result_in,
  input  logic              cs_n,
  input  logic              sclk_in,
  input  logic              sdin,
  output logic              sclk_out,
  output logic              sync_out,
  output logic              sdout,
  output logic              rd_err
);
  logic [1:0] rst_q, rst_n_nx;
  logic       rst_n_s;
  logic       m_start, m_busy, m_sclk, m_shift;
  sp_slv_t    slv;

  // reset: asserted at once, released after two clock edges
  always_comb rst_n_nx = {rst_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= rst_n_nx;
  end

  assign rst_n_s = rst_q[1];

  assign m_start = !cfg_slave && !m_busy && (cfg_rd_during ? conv_start : eoc);

  sp_slave_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n_s), .sclk_inv(cfg_sclk_inv),
    .sclk_in(sclk_in), .cs_n(cs_n), .sdin(sdin), .slv(slv)
  );

  sp_master_clkgen #(.WORD_W(WORD_W), .DIV(DIV)) u_clkgen (
    .clk(clk), .rst_n(rst_n_s), .start(m_start),
    .busy(m_busy), .sclk_int(m_sclk), .shift(m_shift)
  );

  sp_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n_s), .slave(cfg_slave), .rd_during(cfg_rd_during),
    .eoc(eoc), .result_in(result_in), .m_start(m_start), .m_shift(m_shift),
    .m_busy(m_busy), .slv(slv), .sdout(sdout), .rd_err(rd_err)
  );

  assign sclk_out = m_sclk ^ cfg_sclk_inv;
  assign sync_out = m_busy ^ cfg_sync_inv;

  // R5
  master_start_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    m_start |=> m_busy);
endmodule

// File: tb/adc_serial_port_test.sv
`timescale 1ns/1ps
module adc_serial_port_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_slave, cfg_sclk_inv, cfg_sync_inv, cfg_rd_during;
  logic        conv_start, eoc, cs_n, sclk_in, tb_sdin, chain_en;
  logic [17:0] res_a, res_b;
  logic        a_sclk, a_sync, a_sdout, a_err, a_sdin;
  logic        b_sclk, b_sync, b_sdout, b_err;
  int          total = 0;
  int          bad = 0;
  int          err_seen = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  assign a_sdin = chain_en ? b_sdout : tb_sdin;

  adc_serial_port uut (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_sclk_inv(cfg_sclk_inv),
    .cfg_sync_inv(cfg_sync_inv), .cfg_rd_during(cfg_rd_during), .conv_start(conv_start),
    .eoc(eoc), .result_in(res_a), .cs_n(cs_n), .sclk_in(sclk_in), .sdin(a_sdin),
    .sclk_out(a_sclk), .sync_out(a_sync), .sdout(a_sdout), .rd_err(a_err)
  );

  // upstream port of the chain
  adc_serial_port uut2 (
    .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_sclk_inv(cfg_sclk_inv),
    .cfg_sync_inv(cfg_sync_inv), .cfg_rd_during(cfg_rd_during), .conv_start(conv_start),
    .eoc(eoc), .result_in(res_b), .cs_n(cs_n), .sclk_in(sclk_in), .sdin(1'b0),
    .sclk_out(b_sclk), .sync_out(b_sync), .sdout(b_sdout), .rd_err(b_err)
  );

  always @(posedge clk) if (a_err === 1'b1) err_seen++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_eoc(input logic [17:0] a, input logic [17:0] b);
    res_a = a; res_b = b; eoc = 1'b1;
    @(negedge clk);
    eoc = 1'b0;
  endtask

  // one master frame, checked bit by bit (4 system clocks per bit)
  task automatic m_frame(input bit sinv, input bit cinv, input bit rdc,
                         input logic [17:0] prev, input logic [17:0] cur);
    logic [17:0] exp, got;
    int clk_bad, sync_bad;
    cfg_slave = 1'b0; cfg_sync_inv = sinv; cfg_sclk_inv = cinv; cfg_rd_during = rdc;
    tick(2);
    got = '0; clk_bad = 0; sync_bad = 0;
    if (rdc) begin
      strobe_eoc(prev, 18'h0);
      tick(2);
      check(a_sync == sinv, "R5", "eoc alone starts no read-during-convert frame", 36'(a_sync), 36'(sinv));
      exp = prev;
      conv_start = 1'b1;
      @(negedge clk);
      conv_start = 1'b0;
    end else begin
      exp = cur;
      strobe_eoc(cur, 18'h0);
    end
    for (int k = 0; k < 18; k++) begin
      for (int j = 0; j < 4; j++) begin
        if (j == 0) got[17-k] = a_sdout;
        else if (a_sdout !== exp[17-k]) sync_bad += 100;
        if (a_sclk !== ((j >= 2) ^ cinv)) clk_bad++;
        if (a_sync !== ~sinv) sync_bad++;
        if (k == 5 && j == 0) begin res_a = ~exp; eoc = 1'b1; conv_start = 1'b1; end
        if (k == 5 && j == 1) begin eoc = 1'b0; conv_start = 1'b0; end
        @(negedge clk);
      end
    end
    check(got == exp, "R1", "master word (R5 source, strobes mid-frame ignored)", 36'(got), 36'(exp));
    check(clk_bad == 0, "R2", "master clock pattern / R4 inversion", 36'(clk_bad), 36'd0);
    check(sync_bad == 0, "R3", "sync active and data steady through frame", 36'(sync_bad), 36'd0);
    check({a_sdout, a_sync, a_sclk} == {1'b0, sinv, cinv}, "R8", "idle after 18th period",
          36'({a_sdout, a_sync, a_sclk}), 36'({1'b0, sinv, cinv}));
    tick(4);
  endtask

  // slave bit clocking with cs_n low; exp is MSB-aligned stream
  task automatic s_bits(input int n, input logic [35:0] exp, input string req);
    logic [35:0] got, mask;
    int mid_bad;
    got = '0; mid_bad = 0;
    for (int k = 0; k < n; k++) begin
      got[35-k] = a_sdout;
      sclk_in = ~cfg_sclk_inv;
      tick(4);
      if (k < 35 && a_sdout !== exp[34-k]) mid_bad++;
      sclk_in = cfg_sclk_inv;
      tick(4);
    end
    mask = ~('1 >> n);
    check((got & mask) == (exp & mask), req, "slave stream", got & mask, exp & mask);
    check(mid_bad == 0, "R4", "data changes on the selected launch edge", 36'(mid_bad), 36'd0);
  endtask

  initial begin
    logic [17:0] v, w;
    int e0;
    rst_n = 1'b0; cfg_slave = 1'b0; cfg_sclk_inv = 1'b0; cfg_sync_inv = 1'b0;
    cfg_rd_during = 1'b0; conv_start = 1'b0; eoc = 1'b0; cs_n = 1'b1; sclk_in = 1'b0;
    tb_sdin = 1'b0; chain_en = 1'b0; res_a = '0; res_b = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    check({a_sdout, a_sync, a_sclk, a_err} == 4'b0000, "R8", "reset state",
          36'({a_sdout, a_sync, a_sclk, a_err}), 36'd0);

    // master sweep: sync polarity x clock inversion x read mode
    for (int i = 0; i < 8; i++) begin
      v = 18'((32'h1D2B7 * (i + 3)) ^ (i << 15));
      w = ~v ^ 18'h20001;
      m_frame(i[2], i[1], i[0], w, v);
    end

    // slave single reads, both clock polarities
    for (int c = 0; c < 2; c++) begin
      cfg_slave = 1'b1; cfg_sclk_inv = c[0]; sclk_in = c[0]; cs_n = 1'b1; chain_en = 1'b0;
      tick(6);
      v = 18'h2C5A3 ^ 18'(c * 18'h1111);
      strobe_eoc(v, ~v);
      tick(3);
      check({a_sdout, a_sync, a_sclk} == {1'b0, cfg_sync_inv, c[0]}, "R8",
            "slave idle with chip select high", 36'({a_sdout, a_sync, a_sclk}),
            36'({1'b0, cfg_sync_inv, c[0]}));
      e0 = err_seen;
      cs_n = 1'b0;
      tick(6);
      s_bits(18, {v, 18'h0}, "R1");
      w = v ^ 18'h3FFFF;
      strobe_eoc(w, v);
      tick(2);
      check(err_seen == e0, "R10", "load after full read raises no error", 36'(err_seen - e0), 36'd0);
      check(a_sdout == w[17], "R10", "new word MSB after load", 36'(a_sdout), 36'(w[17]));
      cs_n = 1'b1;
      tick(6);
      check(a_sdout == 1'b0, "R8", "sdout low after chip select release", 36'(a_sdout), 36'd0);
    end

    // two-port chain
    cfg_sclk_inv = 1'b0; sclk_in = 1'b0; chain_en = 1'b1;
    tick(6);
    v = 18'h3A0F5; w = 18'h05C3B;
    strobe_eoc(v, w);
    tick(3);
    cs_n = 1'b0;
    tick(6);
    s_bits(36, {v, w}, "R6");
    cs_n = 1'b1; chain_en = 1'b0;
    tick(6);

    // read cut short by a new result
    v = 18'h1B6E2;
    strobe_eoc(v, 18'h0);
    tick(3);
    cs_n = 1'b0;
    tick(6);
    s_bits(5, {v, 18'h0}, "R7");
    w = 18'h2F019;
    res_a = w; eoc = 1'b1;
    @(negedge clk);
    eoc = 1'b0;
    check(a_err == 1'b1, "R7", "error pulse after cut read", 36'(a_err), 36'd1);
    tick(1);
    check(a_err == 1'b0, "R7", "error pulse lasts one cycle", 36'(a_err), 36'd0);
    check(a_sdout == w[17], "R7", "new word MSB after discard", 36'(a_sdout), 36'(w[17]));
    s_bits(18, {w, 18'h0}, "R7");
    cs_n = 1'b1;
    tick(6);

    // abort by chip select, then a strobe with no clocking
    v = 18'h0A7C4;
    strobe_eoc(v, 18'h0);
    tick(3);
    cs_n = 1'b0;
    tick(6);
    s_bits(5, {v, 18'h0}, "R9");
    cs_n = 1'b1;
    tick(6);
    cs_n = 1'b0;
    tick(6);
    e0 = err_seen;
    w = 18'h35D28;
    strobe_eoc(w, 18'h0);
    tick(2);
    check(err_seen == e0, "R9", "no error after aborted read", 36'(err_seen - e0), 36'd0);
    s_bits(18, {w, 18'h0}, "R9");
    cs_n = 1'b1;
    tick(6);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule